// File: doc/BRIEF.md
# Sliding Sub-Window Record Dispatcher

This block sits at the front of a signature-matching pipeline. It takes one byte per accepted transfer and keeps the three most recent bytes in a window. New bytes enter at the most significant end. Each time the window moves, the block forms three suffix sub-windows: the newest byte alone, the newest two bytes, and all three bytes. It looks each one up in a table of its own. The one-byte table is indexed directly by the byte. The two- and three-byte tables are small hashed RAMs that store the full key, so an entry at the hashed slot whose key differs is rejected.

Each lookup yields either a stored record or an all-zero record. The three results are registered onto three detection-unit output lanes. The lane-to-table mapping rotates by one step on every accepted byte, so each downstream unit sees the one-, two- and three-byte tables in turn. A host write port fills and invalidates table entries. While a write is presented, the block refuses input bytes, so the window never moves during an update.

Top module: `swd_dispatch`

## Requirements
- R1: After reset, out_valid is 0, out_rec, out_src and out_full are all zero, and in_ready is 1 while wr_en is low.
- R2: An accepted byte becomes the newest window byte (bits 23:16); the previous two move down to 15:8 and 7:0. Sub-window keys are the top 8, 16 or 24 window bits, with the newest byte as the key's most significant byte.
- R3: The one-byte table has 256 entries indexed directly by the byte value (wr_addr carries the byte); an entry hits when its valid bit is set.
- R4: A two-byte entry sits at slot (k[15:8] XOR k[7:0]) mod 16, and a three-byte entry at slot ((k[23:16] XOR k[15:8]) + k[7:0]) mod 16, where k is the key in wr_key's low bits. A hit needs the slot valid and the stored key equal to the sub-window.
- R5: A sub-window that does not hit produces an all-zero record on its lane.
- R6: Records are {BV[L], EV[L], weights[M*WW], base[BAW], hash_sel[HSW]}, MSB first (38 bits by default). Records from the one- and two-byte tables always carry BV = 0, whatever was written.
- R7: For the k-th accepted byte since reset (k from 0), lane u takes table s = (u + k) mod 3, where 0 is the one-byte table, 1 the two-byte table and 2 the three-byte table. out_src for lane u is s, and out_full[u] is 1 exactly when s = 2. Lane u occupies out_rec bits [u*38 +: 38].
- R8: Until n bytes have been accepted since reset, the n-byte sub-window never hits.
- R9: in_ready is 0 whenever wr_en is 1. A byte presented without being accepted leaves the window unchanged, and all outputs hold their values.
- R10: out_valid is 1 in exactly the one cycle after each accepted byte.
- R11: Host writes take effect for lookups that follow them, and a write with wr_vld = 0 removes the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can accept a byte |
| in_char | input | 8 | Input byte |
| wr_en | input | 1 | Host table write strobe |
| wr_sel | input | 2 | Table select: 0 one-byte, 1 two-byte, 2 three-byte |
| wr_addr | input | 8 | Slot to write |
| wr_key | input | 24 | Key, right-aligned |
| wr_vld | input | 1 | Valid bit written with the entry |
| wr_rec | input | 38 | Record to store |
| out_valid | output | 1 | Lanes updated this cycle |
| out_rec | output | 114 | Three lane records |
| out_src | output | 6 | Per-lane table index, 2 bits each |
| out_full | output | 3 | Per-lane full-width (three-byte) tag |

## Verification
The assertions rely on the host computing the hashed slot itself and never asserting wr_en together with a byte it expects to be taken. They also take for granted that rst_n is held for at least one edge before traffic starts. The stimulus places every entry at the slot given by R4, and lets the block refuse a byte that is offered during a write rather than counting it as sent. It applies reset once, before any write or byte. The stream deliberately includes key pairs that share a slot, so the key-compare path is exercised as well as the valid path.

// File: rtl/swd_pkg.sv
package swd_pkg;

  // Lane u reads table (u + phase) mod nc.
  function automatic int unsigned unit_source(int unsigned unit, int unsigned phase,
                                              int unsigned nc);
    return (unit + phase) % nc;
  endfunction

  function automatic int unsigned phase_advance(int unsigned phase, int unsigned nc);
    return (phase + 1 >= nc) ? 0 : phase + 1;
  endfunction

  // Fold an nch-byte key (right-aligned, newest byte highest) into 8 bits:
  // start from the newest byte, then alternately XOR and add older bytes.
  function automatic logic [7:0] key_fold(logic [63:0] key, int unsigned nch);
    logic [7:0] h;
    logic [7:0] b;
    h = key[8*(nch-1) +: 8];
    for (int j = 1; j < 8; j++) begin
      if (j < nch) begin
        b = key[8*(nch-1-j) +: 8];
        h = (j % 2 == 1) ? (h ^ b) : (h + b);
      end
    end
    return h;
  endfunction

endpackage

// File: rtl/swd_window.sv
module swd_window #(
  parameter int NC = 3,
  parameter int CW = 8,
  localparam int WINW = NC * CW,
  localparam int FW = $clog2(NC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift,
  input  logic [CW-1:0]   ch,
  output logic [WINW-1:0] nxt_win,
  output logic [FW-1:0]   nxt_fill,
  output logic [FW-1:0]   fill_now
);
  logic [WINW-1:0] win_q;
  logic [FW-1:0]   fill_q;

  always_comb begin
    nxt_win  = shift ? {ch, win_q[WINW-1:CW]} : win_q;
    nxt_fill = (shift && (fill_q < FW'(NC))) ? fill_q + FW'(1) : fill_q;
  end

  assign fill_now = fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      win_q  <= nxt_win;
      fill_q <= nxt_fill;
    end
  end

  p_win_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> win_q == $past(win_q));
  p_fill_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FW'(NC));
endmodule

// File: rtl/swd_lut.sv
module swd_lut #(
  parameter int NCH = 1,
  parameter int AW  = 8,
  parameter int STW = 30,
  localparam int KEYW  = 8 * NCH,
  localparam int DEPTH = 1 << AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [KEYW-1:0] wkey,
  input  logic            wvld,
  input  logic [STW-1:0]  wdata,
  input  logic [KEYW-1:0] lkey,
  output logic            hit,
  output logic [STW-1:0]  rdata
);
  import swd_pkg::*;

  logic [DEPTH-1:0] vld_q;
  logic [STW-1:0]   mem_q [DEPTH];
  logic [7:0]       fold;
  logic [AW-1:0]    idx;
  logic             key_ok;

  assign fold = key_fold(64'(lkey), NCH);
  assign idx  = AW'(fold);

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (we) vld_q[waddr] <= wvld;
  end

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  generate
    if (NCH == 1) begin : g_direct
      assign key_ok = 1'b1;
      logic unused_wkey;
      assign unused_wkey = ^wkey;
    end else begin : g_keyed
      logic [KEYW-1:0] key_q [DEPTH];
      always_ff @(posedge clk) begin
        if (we) key_q[waddr] <= wkey;
      end
      assign key_ok = (key_q[idx] == lkey);
    end
  endgenerate

  assign hit   = vld_q[idx] && key_ok;
  assign rdata = hit ? mem_q[idx] : '0;
endmodule

// File: rtl/swd_rotator.sv
module swd_rotator #(
  parameter int NC   = 3,
  parameter int RECW = 38,
  parameter int SW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic [NC*RECW-1:0] tab_rec,
  output logic [NC*RECW-1:0] sel_rec,
  output logic [NC*SW-1:0]   sel_src
);
  import swd_pkg::*;

  logic [SW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else if (adv) phase_q <= SW'(phase_advance(int'(phase_q), NC));
  end

  for (genvar u = 0; u < NC; u++) begin : g_lane
    logic [RECW-1:0] rec_l;
    logic [SW-1:0]   src_l;
    always_comb begin
      int unsigned s;
      s     = unit_source(u, int'(phase_q), NC);
      rec_l = tab_rec[s*RECW +: RECW];
      src_l = SW'(s);
    end
    assign sel_rec[u*RECW +: RECW] = rec_l;
    assign sel_src[u*SW +: SW]     = src_l;
  end

  p_phase_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < SW'(NC));
endmodule

// File: rtl/swd_dispatch.sv
module swd_dispatch #(
  parameter int NC       = 3,
  parameter int L        = 8,
  parameter int M        = 2,
  parameter int WW       = 8,
  parameter int BAW      = 4,
  parameter int HSW      = 2,
  parameter int AW_MULTI = 4,
  localparam int CW    = 8,
  localparam int WINW  = NC * CW,
  localparam int RECW  = 2*L + M*WW + BAW + HSW,
  localparam int SRECW = RECW - L,
  localparam int SW    = $clog2(NC),
  localparam int FW    = $clog2(NC + 1),
  localparam int WAW   = (AW_MULTI > 8) ? AW_MULTI : 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CW-1:0]      in_char,
  input  logic               wr_en,
  input  logic [SW-1:0]      wr_sel,
  input  logic [WAW-1:0]     wr_addr,
  input  logic [WINW-1:0]    wr_key,
  input  logic               wr_vld,
  input  logic [RECW-1:0]    wr_rec,
  output logic               out_valid,
  output logic [NC*RECW-1:0] out_rec,
  output logic [NC*SW-1:0]   out_src,
  output logic [NC-1:0]      out_full
);
  logic               accept;
  logic [WINW-1:0]    nxt_win;
  logic [FW-1:0]      nxt_fill;
  logic [FW-1:0]      win_fill;
  logic [NC*RECW-1:0] tab_rec;
  logic [NC*RECW-1:0] sel_rec;
  logic [NC*SW-1:0]   sel_src;

  assign in_ready = !wr_en;
  assign accept   = in_valid && in_ready;

  swd_window #(.NC(NC), .CW(CW)) win_i (
    .clk(clk), .rst_n(rst_n), .shift(accept), .ch(in_char),
    .nxt_win(nxt_win), .nxt_fill(nxt_fill), .fill_now(win_fill)
  );

  for (genvar g = 0; g < NC; g++) begin : g_tab
    localparam int NCH = g + 1;
    localparam int TAW = (g == 0) ? 8 : AW_MULTI;
    localparam int STW = (g == NC - 1) ? RECW : SRECW;
    logic            hit;
    logic [STW-1:0]  rdata;
    logic [RECW-1:0] rec_full;
    logic            we;

    assign we = wr_en && (wr_sel == SW'(g));

    swd_lut #(.NCH(NCH), .AW(TAW), .STW(STW)) lut_i (
      .clk(clk), .rst_n(rst_n), .we(we),
      .waddr(wr_addr[TAW-1:0]),
      .wkey(wr_key[8*NCH-1:0]),
      .wvld(wr_vld),
      .wdata(wr_rec[STW-1:0]),
      .lkey(nxt_win[WINW-1 -: 8*NCH]),
      .hit(hit), .rdata(rdata)
    );

    if (g == NC - 1) begin : g_wide
      assign rec_full = RECW'(rdata);
    end else begin : g_narrow
      assign rec_full = {{L{1'b0}}, rdata};
    end

    // A sub-window only counts once the window holds enough bytes.
    assign tab_rec[g*RECW +: RECW] = (hit && (nxt_fill > FW'(g))) ? rec_full : '0;
  end

  swd_rotator #(.NC(NC), .RECW(RECW), .SW(SW)) rot_i (
    .clk(clk), .rst_n(rst_n), .adv(accept),
    .tab_rec(tab_rec), .sel_rec(sel_rec), .sel_src(sel_src)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rec   <= '0;
      out_src   <= '0;
      out_full  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_rec <= sel_rec;
        out_src <= sel_src;
        for (int u = 0; u < NC; u++)
          out_full[u] <= (sel_src[u*SW +: SW] == SW'(NC - 1));
      end
    end
  end

  p_write_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !out_valid);
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready));
  p_one_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot(out_full));

  for (genvar u = 0; u < NC; u++) begin : g_chk
    p_short_no_bv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_full[u] |-> out_rec[u*RECW + RECW - 1 -: L] == '0);
    p_first_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (win_fill == '0) |=>
        (out_src[u*SW +: SW] == '0) || (out_rec[u*RECW +: RECW] == '0));
  end
endmodule

// File: tb/swd_dispatch_tb_top.sv
module swd_dispatch_tb_top;
  localparam int NC = 3, L = 8, RECW = 38, SRECW = 30, SW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_ready, wr_en, wr_vld, out_valid;
  logic [7:0] in_char, wr_addr;
  logic [SW-1:0] wr_sel;
  logic [23:0] wr_key;
  logic [RECW-1:0] wr_rec;
  logic [NC*RECW-1:0] out_rec;
  logic [NC*SW-1:0] out_src;
  logic [NC-1:0] out_full;

  swd_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_char(in_char), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_key(wr_key), .wr_vld(wr_vld), .wr_rec(wr_rec), .out_valid(out_valid),
    .out_rec(out_rec), .out_src(out_src), .out_full(out_full)
  );

  typedef struct {
    logic [NC*RECW-1:0] rec;
    logic [NC*SW-1:0]   src;
    logic [NC-1:0]      full;
    string              tag;
  } exp_t;

  exp_t q[$];
  exp_t cur, last;
  bit have_last = 0, run = 0, done = 0;
  int errs = 0, checks = 0;

  // reference tables
  logic              m1_v [256];
  logic [SRECW-1:0]  m1_r [256];
  logic              m2_v [16];
  logic [15:0]       m2_k [16];
  logic [SRECW-1:0]  m2_r [16];
  logic              m3_v [16];
  logic [23:0]       m3_k [16];
  logic [RECW-1:0]   m3_r [16];
  logic [23:0] mw = '0;
  int mfill = 0, mk = 0;

  task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] slot2(logic [7:0] a, logic [7:0] b);
    logic [7:0] t;
    t = a ^ b;
    return t[3:0];
  endfunction

  function automatic logic [3:0] slot3(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    logic [7:0] t;
    t = (a ^ b) + c;
    return t[3:0];
  endfunction

  function automatic logic [RECW-1:0] mkrec(logic [7:0] s);
    return {6'h2A, s, ~s, s ^ 8'h5A, s + 8'h11};
  endfunction

  task automatic wr(int sel, logic [23:0] key, bit vld, logic [7:0] seed, bit offer);
    logic [3:0] a;
    @(negedge clk);
    wr_en = 1; wr_sel = SW'(sel); wr_key = key; wr_vld = vld; wr_rec = mkrec(seed);
    in_valid = offer; in_char = 8'h5A;
    case (sel)
      0: begin wr_addr = key[7:0]; m1_v[key[7:0]] = vld; m1_r[key[7:0]] = wr_rec[SRECW-1:0]; end
      1: begin a = slot2(key[15:8], key[7:0]); wr_addr = {4'h0, a};
               m2_v[a] = vld; m2_k[a] = key[15:0]; m2_r[a] = wr_rec[SRECW-1:0]; end
      default: begin a = slot3(key[23:16], key[15:8], key[7:0]); wr_addr = {4'h0, a};
               m3_v[a] = vld; m3_k[a] = key; m3_r[a] = wr_rec; end
    endcase
    #1 chk(in_ready == 1'b0, "R9", "ready during write", 128'(in_ready), 0);
    @(posedge clk); #1 wr_en = 0; in_valid = 0;
  endtask

  task automatic send(logic [7:0] c, string tag);
    exp_t e;
    logic [7:0] c1, c2, c3;
    logic [3:0] a;
    @(negedge clk);
    in_valid = 1; in_char = c;
    mw = {c, mw[23:8]};
    if (mfill < 3) mfill++;
    c1 = mw[23:16]; c2 = mw[15:8]; c3 = mw[7:0];
    for (int u = 0; u < NC; u++) begin
      int s;
      logic [RECW-1:0] r;
      s = (u + mk) % 3;
      r = '0;
      if (s == 0) begin
        if (m1_v[c1]) r = {8'h00, m1_r[c1]};
      end else if (s == 1) begin
        a = slot2(c1, c2);
        if (mfill >= 2 && m2_v[a] && m2_k[a] == {c1, c2}) r = {8'h00, m2_r[a]};
      end else begin
        a = slot3(c1, c2, c3);
        if (mfill >= 3 && m3_v[a] && m3_k[a] == {c1, c2, c3}) r = m3_r[a];
      end
      e.rec[u*RECW +: RECW] = r;
      e.src[u*SW +: SW] = SW'(s);
      e.full[u] = (s == 2);
    end
    e.tag = tag;
    q.push_back(e);
    mk = (mk + 1) % 3;
    @(posedge clk); #1 in_valid = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (run) begin
      if (out_valid) begin
        if (q.size() == 0) chk(0, "R10", "unexpected out_valid", 1, 0);
        else begin
          cur = q.pop_front();
          chk(out_rec == cur.rec, cur.tag, "lane records", 128'(out_rec), 128'(cur.rec));
          chk(out_src == cur.src, "R7", "lane sources", 128'(out_src), 128'(cur.src));
          chk(out_full == cur.full, "R7", "full tags", 128'(out_full), 128'(cur.full));
          last = cur; have_last = 1;
        end
      end else if (have_last) begin
        chk(out_rec == last.rec && out_src == last.src, "R9", "outputs hold",
            128'(out_rec), 128'(last.rec));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL R10 watchdog expired act=%0d exp=%0d", q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin m1_v[i] = 0; m1_r[i] = '0; end
    for (int i = 0; i < 16; i++) begin
      m2_v[i] = 0; m2_k[i] = '0; m2_r[i] = '0; m3_v[i] = 0; m3_k[i] = '0; m3_r[i] = '0;
    end
    rst_n = 0; in_valid = 0; in_char = 0; wr_en = 0; wr_sel = 0; wr_addr = 0;
    wr_key = 0; wr_vld = 0; wr_rec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1", "out_valid", 128'(out_valid), 0);
    chk(out_rec == 0 && out_src == 0 && out_full == 0, "R1", "outputs zero", 128'(out_rec), 0);
    chk(in_ready == 1, "R1", "in_ready", 128'(in_ready), 1);
    rst_n = 1; run = 1;

    // R8: entries that would match the zero-filled window too early
    wr(0, 24'h000041, 1, 8'h01, 0);
    wr(1, 24'h004100, 1, 8'h02, 0);
    wr(2, 24'h410000, 1, 8'h03, 0);
    wr(2, 24'h424100, 1, 8'h04, 0);
    send(8'h41, "R8");
    send(8'h42, "R8");

    // R9: byte offered during a write is refused
    wr(0, 24'h000043, 1, 8'h05, 1);
    @(negedge clk);
    chk(out_valid == 0, "R9", "refused byte", 128'(out_valid), 0);

    // populate tables; short records get nonzero BV bits (R6)
    wr(0, 24'h000042, 1, 8'h06, 0);
    wr(0, 24'h000044, 1, 8'h07, 0);
    wr(0, 24'h0000FF, 1, 8'h08, 0);
    wr(1, 24'h004241, 1, 8'h09, 0);
    wr(1, 24'h004342, 1, 8'h0A, 0);
    wr(1, 24'h004443, 1, 8'h0B, 0);
    wr(1, 24'h004144, 1, 8'h0C, 0);
    wr(2, 24'h434241, 1, 8'h0D, 0);
    wr(2, 24'h444342, 1, 8'h0E, 0);
    wr(2, 24'h414443, 1, 8'h0F, 0);
    send(8'h43, "R2");
    send(8'h44, "R6");
    send(8'h41, "R2");
    // R4: key 0x4142 shares slot with stored 0x4241
    send(8'h42, "R4");
    send(8'h41, "R4");
    send(8'h43, "R5");
    send(8'h42, "R4");
    send(8'h41, "R2");
    send(8'hFF, "R3");
    send(8'h00, "R5");
    for (int i = 0; i < 12; i++) begin
      send(8'h41 + 8'(i % 4), "R2");
      if (i % 3 == 0) @(negedge clk);
    end
    // R11: removal and rewrite
    wr(2, 24'h434241, 0, 8'h10, 0);
    wr(0, 24'h000042, 1, 8'h20, 0);
    send(8'h41, "R11");
    send(8'h42, "R11");
    send(8'h43, "R11");
    send(8'h44, "R11");
    send(8'h41, "R11");
    send(8'h42, "R11");
    send(8'h43, "R11");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R10", "all outputs seen", 128'(q.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule